// File: doc/BRIEF.md
# One-Hot Virtual Register Map

This block keeps, for every virtual register number, the physical register entry it currently names. Each mapping sits in a row of one bit per physical entry, with at most one bit set. A looked-up row can therefore drive the per-entry enable lines of a register storage array directly, without an address decoder between the table and the storage cells.

A mapping update gives a virtual index and a binary physical index. The block decodes the physical index once, at write time, and stores the resulting one-hot row in place of whatever the row held before. A lookup gives a virtual index. One cycle later the block presents the selected row as a one-hot enable vector, with a valid flag. For storage that accepts only binary addresses, an optional encoder also presents the same selection as a binary index.

When a lookup and an update name the same virtual index in the same cycle, the lookup takes the new mapping. A consumer never sees a row that is about to be replaced.

Top module: `vrm_map`

## Requirements
- R1: While rst_n is low, and after it is released, every row is cleared. lk_onehot, lk_valid and lk_bin all read zero until the first lookup.
- R2: An update with upd_en high at a clock edge stores a row with only bit upd_pidx set for virtual index upd_vidx. The row is visible from the next cycle and fully replaces the earlier row, so the earlier bit is cleared.
- R3: Each stored row, and the lk_onehot output, has at most one bit set.
- R4: A lookup with lk_en high at a clock edge puts the row of lk_vidx on lk_onehot after that edge. Bit p set means physical entry p. lk_valid is 1 exactly when that row is non-zero.
- R5: A lookup of a virtual index never written since reset returns lk_onehot all zero and lk_valid 0.
- R6: When upd_en and lk_en are both high in one cycle with upd_vidx equal to lk_vidx, the lookup result is the row being written, not the old row.
- R7: lk_bin is the position of the set bit in lk_onehot (bit p gives value p), and is zero when lk_valid is 0.
- R8: While lk_en is low, lk_onehot, lk_valid and lk_bin keep their last values, even if updates occur.
- R9: An update changes only the row of upd_vidx. A same-cycle update to a different index does not change the lookup result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| upd_en | input | 1 | Write a new mapping this cycle |
| upd_vidx | input | VW = clog2(NUM_VIRT) | Virtual index being remapped |
| upd_pidx | input | PW = clog2(NUM_PHYS) | Binary physical index of the new mapping |
| lk_en | input | 1 | Perform a lookup this cycle |
| lk_vidx | input | VW | Virtual index looked up |
| lk_valid | output | 1 | Looked-up row holds a mapping |
| lk_onehot | output | NUM_PHYS | One-hot enable vector across physical entries |
| lk_bin | output | PW | Binary form of lk_onehot (zero when BIN_OUT is 0) |

## Verification
An update and a lookup can land in the same cycle, and the interesting case is when both name the same virtual index. The bench drives both in one cycle, both on an index that already holds a mapping and on one that holds none. It expects the new physical entry in the following cycle, where the old row would be wrong. It also pairs an update with a lookup of a different index, and expects the old row of that index unchanged. Every lookup result, in one-hot, valid and binary form, is compared to a model kept in the bench.

// File: rtl/vrm_pkg.sv
package vrm_pkg;
  localparam int DEF_NUM_VIRT = 16;
  localparam int DEF_NUM_PHYS = 128;
endpackage

// File: rtl/vrm_dec.sv
module vrm_dec #(
  parameter int NUM_PHYS = vrm_pkg::DEF_NUM_PHYS,
  localparam int PW = $clog2(NUM_PHYS)
) (
  input  logic [PW-1:0]       idx,
  output logic [NUM_PHYS-1:0] onehot
);
  // One comparator per physical entry; an index beyond NUM_PHYS gives all zero.
  for (genvar p = 0; p < NUM_PHYS; p++) begin : g_bit
    assign onehot[p] = (idx == PW'(p));
  end
endmodule

// File: rtl/vrm_rows.sv
module vrm_rows #(
  parameter int NUM_VIRT = vrm_pkg::DEF_NUM_VIRT,
  parameter int NUM_PHYS = vrm_pkg::DEF_NUM_PHYS,
  localparam int VW = $clog2(NUM_VIRT)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                upd_en,
  input  logic [VW-1:0]       upd_vidx,
  input  logic [NUM_PHYS-1:0] new_row,
  output logic [NUM_PHYS-1:0] row_q [NUM_VIRT]
);
  for (genvar r = 0; r < NUM_VIRT; r++) begin : g_row
    logic                row_we;
    logic [NUM_PHYS-1:0] row_d;

    always_comb begin
      row_we = upd_en && (upd_vidx == VW'(r));
      row_d  = row_we ? new_row : row_q[r];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) row_q[r] <= '0;
      else        row_q[r] <= row_d;
    end
  end
endmodule

// File: rtl/vrm_read.sv
module vrm_read #(
  parameter int NUM_VIRT = vrm_pkg::DEF_NUM_VIRT,
  parameter int NUM_PHYS = vrm_pkg::DEF_NUM_PHYS,
  localparam int VW = $clog2(NUM_VIRT)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_PHYS-1:0] row_q [NUM_VIRT],
  input  logic                upd_en,
  input  logic [VW-1:0]       upd_vidx,
  input  logic [NUM_PHYS-1:0] new_row,
  input  logic                lk_en,
  input  logic [VW-1:0]       lk_vidx,
  output logic [NUM_PHYS-1:0] oh_q,
  output logic                valid_q
);
  logic                collide;
  logic [NUM_PHYS-1:0] sel_row;
  logic [NUM_PHYS-1:0] oh_d;
  logic                valid_d;

  always_comb begin
    collide = upd_en && (upd_vidx == lk_vidx);
    sel_row = collide ? new_row : row_q[lk_vidx];
    oh_d    = lk_en ? sel_row : oh_q;
    valid_d = lk_en ? (|sel_row) : valid_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      oh_q    <= '0;
      valid_q <= 1'b0;
    end else begin
      oh_q    <= oh_d;
      valid_q <= valid_d;
    end
  end
endmodule

// File: rtl/vrm_enc.sv
module vrm_enc #(
  parameter int NUM_PHYS = vrm_pkg::DEF_NUM_PHYS,
  localparam int PW = $clog2(NUM_PHYS)
) (
  input  logic [NUM_PHYS-1:0] onehot,
  output logic [PW-1:0]       bin
);
  // With at most one bit set, OR-ing the indices of set bits gives that index.
  always_comb begin
    bin = '0;
    for (int i = 0; i < NUM_PHYS; i++) begin
      if (onehot[i]) bin = bin | PW'(i);
    end
  end
endmodule

// File: rtl/vrm_map.sv
module vrm_map #(
  parameter int NUM_VIRT = vrm_pkg::DEF_NUM_VIRT,
  parameter int NUM_PHYS = vrm_pkg::DEF_NUM_PHYS,
  parameter bit BIN_OUT  = 1'b1,
  localparam int VW = $clog2(NUM_VIRT),
  localparam int PW = $clog2(NUM_PHYS)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                upd_en,
  input  logic [VW-1:0]       upd_vidx,
  input  logic [PW-1:0]       upd_pidx,
  input  logic                lk_en,
  input  logic [VW-1:0]       lk_vidx,
  output logic                lk_valid,
  output logic [NUM_PHYS-1:0] lk_onehot,
  output logic [PW-1:0]       lk_bin
);
  logic [NUM_PHYS-1:0] new_row;
  logic [NUM_PHYS-1:0] row_q [NUM_VIRT];

  vrm_dec #(.NUM_PHYS(NUM_PHYS)) u_dec (
    .idx    (upd_pidx),
    .onehot (new_row)
  );

  vrm_rows #(.NUM_VIRT(NUM_VIRT), .NUM_PHYS(NUM_PHYS)) u_rows (
    .clk      (clk),
    .rst_n    (rst_n),
    .upd_en   (upd_en),
    .upd_vidx (upd_vidx),
    .new_row  (new_row),
    .row_q    (row_q)
  );

  vrm_read #(.NUM_VIRT(NUM_VIRT), .NUM_PHYS(NUM_PHYS)) u_read (
    .clk      (clk),
    .rst_n    (rst_n),
    .row_q    (row_q),
    .upd_en   (upd_en),
    .upd_vidx (upd_vidx),
    .new_row  (new_row),
    .lk_en    (lk_en),
    .lk_vidx  (lk_vidx),
    .oh_q     (lk_onehot),
    .valid_q  (lk_valid)
  );

  if (BIN_OUT) begin : g_bin
    vrm_enc #(.NUM_PHYS(NUM_PHYS)) u_enc (
      .onehot (lk_onehot),
      .bin    (lk_bin)
    );
  end else begin : g_nobin
    assign lk_bin = '0;
  end
endmodule

// File: rtl/vrm_map_chk.sv
module vrm_map_chk #(
  parameter int NUM_VIRT = vrm_pkg::DEF_NUM_VIRT,
  parameter int NUM_PHYS = vrm_pkg::DEF_NUM_PHYS,
  parameter bit BIN_OUT  = 1'b1,
  localparam int VW = $clog2(NUM_VIRT),
  localparam int PW = $clog2(NUM_PHYS)
) (
  input logic                clk,
  input logic                rst_n,
  input logic                upd_en,
  input logic [VW-1:0]       upd_vidx,
  input logic [PW-1:0]       upd_pidx,
  input logic                lk_en,
  input logic [VW-1:0]       lk_vidx,
  input logic                lk_valid,
  input logic [NUM_PHYS-1:0] lk_onehot,
  input logic [PW-1:0]       lk_bin,
  input logic [NUM_PHYS-1:0] rows [NUM_VIRT]
);
  localparam logic [NUM_PHYS-1:0] ONE = NUM_PHYS'(1);

  for (genvar r = 0; r < NUM_VIRT; r++) begin : g_rowchk
    a_r3_row_onehot: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(rows[r]));
    a_r2_row_written: assert property (@(posedge clk) disable iff (!rst_n)
      (upd_en && upd_vidx == VW'(r)) |=> (rows[r] == (ONE << $past(upd_pidx))));
  end

  a_r3_out_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(lk_onehot));

  a_r4_valid_flag: assert property (@(posedge clk) disable iff (!rst_n)
    lk_valid == (lk_onehot != '0));

  a_r6_same_index_bypass: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_en && upd_en && upd_vidx == lk_vidx) |=> (lk_onehot == (ONE << $past(upd_pidx))));

  a_r8_hold_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_en |=> ($stable(lk_onehot) && $stable(lk_valid) && $stable(lk_bin)));

  if (BIN_OUT) begin : g_binchk
    a_r7_bin_matches: assert property (@(posedge clk) disable iff (!rst_n)
      lk_valid |-> lk_onehot[lk_bin]);
    a_r7_bin_zero: assert property (@(posedge clk) disable iff (!rst_n)
      !lk_valid |-> (lk_bin == '0));
  end
endmodule

bind vrm_map vrm_map_chk #(
  .NUM_VIRT (NUM_VIRT),
  .NUM_PHYS (NUM_PHYS),
  .BIN_OUT  (BIN_OUT)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .upd_en    (upd_en),
  .upd_vidx  (upd_vidx),
  .upd_pidx  (upd_pidx),
  .lk_en     (lk_en),
  .lk_vidx   (lk_vidx),
  .lk_valid  (lk_valid),
  .lk_onehot (lk_onehot),
  .lk_bin    (lk_bin),
  .rows      (row_q)
);

// File: tb/vrm_map_test.sv
`timescale 1ns/1ps
module vrm_map_test;
  localparam int NV = 16;
  localparam int NP = 128;
  localparam int VW = 4;
  localparam int PW = 7;
  localparam logic [NP-1:0] ONE = NP'(1);

  logic          clk;
  logic          rst_n;
  logic          upd_en;
  logic [VW-1:0] upd_vidx;
  logic [PW-1:0] upd_pidx;
  logic          lk_en;
  logic [VW-1:0] lk_vidx;
  logic          lk_valid;
  logic [NP-1:0] lk_onehot;
  logic [PW-1:0] lk_bin;

  vrm_map #(.NUM_VIRT(NV), .NUM_PHYS(NP), .BIN_OUT(1'b1)) uut (
    .clk (clk), .rst_n (rst_n),
    .upd_en (upd_en), .upd_vidx (upd_vidx), .upd_pidx (upd_pidx),
    .lk_en (lk_en), .lk_vidx (lk_vidx),
    .lk_valid (lk_valid), .lk_onehot (lk_onehot), .lk_bin (lk_bin)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  typedef struct {
    int    pidx;
    string tag;
  } exp_t;

  exp_t q[$];
  int   model [NV];
  int   n_chk  = 0;
  int   n_fail = 0;
  bit   done   = 1'b0;
  bit   lk_prev = 1'b0;
  int   last_p = -1;

  always @(posedge clk) lk_prev <= lk_en;

  task automatic compare(input int p, input string tag);
    logic [NP-1:0] e_oh;
    logic          e_v;
    logic [PW-1:0] e_b;
    e_oh = (p < 0) ? '0 : (ONE << p);
    e_v  = (p >= 0);
    e_b  = (p < 0) ? '0 : PW'(p);
    n_chk++;
    if (lk_onehot !== e_oh || lk_valid !== e_v || lk_bin !== e_b) begin
      n_fail++;
      $display("FAIL %s: onehot=%h valid=%b bin=%0d expected onehot=%h valid=%b bin=%0d",
               tag, lk_onehot, lk_valid, lk_bin, e_oh, e_v, e_b);
    end
  endtask

  // Monitor: results appear the cycle after the lookup edge.
  always @(negedge clk) begin
    if (rst_n && !done) begin
      if (lk_prev) begin
        if (q.size() == 0) begin
          n_chk++; n_fail++;
          $display("FAIL R4: result with empty scoreboard");
        end else begin
          exp_t it;
          it = q.pop_front();
          compare(it.pidx, it.tag);
          last_p = it.pidx;
        end
      end else begin
        compare(last_p, "R8 hold while idle");
      end
    end
  end

  // Driver: one cycle of stimulus, expectation pushed into the scoreboard.
  task automatic step(input bit ue, input int uv, input int up,
                      input bit le, input int lv, input string tag);
    @(negedge clk);
    upd_en   = ue;
    upd_vidx = VW'(uv);
    upd_pidx = PW'(up);
    lk_en    = le;
    lk_vidx  = VW'(lv);
    if (le) begin
      exp_t it;
      it.pidx = (ue && uv == lv) ? up : model[lv];
      it.tag  = tag;
      q.push_back(it);
    end
    if (ue) model[uv] = up;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    for (int i = 0; i < NV; i++) model[i] = -1;
    rst_n = 1'b0; upd_en = 0; upd_vidx = 0; upd_pidx = 0; lk_en = 0; lk_vidx = 0;
    repeat (3) @(negedge clk);
    compare(-1, "R1 outputs in reset");
    rst_n = 1'b1;
    @(negedge clk);
    compare(-1, "R1 outputs after reset");

    step(0, 0, 0,   1, 3,  "R5 unmapped lookup");
    step(1, 3, 5,   0, 0,  "");
    step(0, 0, 0,   1, 3,  "R2 R4 first mapping");
    step(1, 3, 100, 1, 3,  "R6 same-index bypass over old row");
    step(0, 0, 0,   1, 3,  "R2 replacement clears old bit");
    step(1, 9, 42,  1, 9,  "R6 bypass on unmapped index");
    step(1, 0, 127, 0, 0,  "");
    step(1, 15, 0,  0, 0,  "");
    step(0, 0, 0,   1, 15, "R7 bin of entry 0");
    step(0, 0, 0,   1, 0,  "R7 bin of top entry");
    step(1, 4, 7,   1, 5,  "R9 update elsewhere same cycle");
    step(1, 5, 9,   0, 0,  "");
    step(1, 6, 11,  0, 0,  "");
    step(0, 0, 0,   0, 0,  "");
    step(0, 0, 0,   1, 3,  "R9 row untouched by others");
    step(0, 0, 0,   1, 4,  "R4 lookup after idle");
    for (int v = 0; v < NV; v++) step(1, v, v * 8 + 3, 0, 0, "");
    for (int v = 0; v < NV; v++) step(0, 0, 0, 1, v, "R4 R3 sweep");
    step(0, 0, 0,   0, 0,  "");
    step(0, 0, 0,   0, 0,  "");
    if (q.size() != 0) begin
      n_chk++; n_fail++;
      $display("FAIL R4: %0d results missing, expected 0", q.size());
    end
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule